// File: doc/BRIEF.md
# Segment Translation Unit

This unit turns a logical address, made of a 16-bit selector and a 32-bit offset, into a 32-bit linear address. The unit splits the selector into a descriptor index, a table choice and a requested privilege. It picks either the global or the local descriptor table. Before any memory access, it checks that the whole 8-byte entry lies inside the chosen table. It then fetches the descriptor as two 32-bit words and rebuilds the scattered base and limit fields. It scales the limit by the granularity flag and tests the present flag and the offset bound. The result is either a linear address or a fault code.

A client offers one translation at a time on a valid/ready request port. Each translation ends in a single-cycle response that carries the following items:
- the linear address
- a 2-bit fault code
- the descriptor privilege and the requested privilege
- the 4-bit type
- the default-size flag

The two table registers are plain inputs. They must stay stable while a translation is in progress. The reset is asynchronous and active low. Inside the block it is released through a two-stage synchronizer.

Top module: `seg_xlate`

## Requirements
- R1: The selector is decoded as index = bits 15:3, table choice = bit 2 and requested privilege = bits 1:0. The requested privilege is returned unchanged on `rsp_rpl`.
- R2: Table choice 0 uses `gtab_base`/`gtab_lim`. Table choice 1 uses `ltab_base`/`ltab_lim`.
- R3: The descriptor sits at table base + index×8. It is read as two words: the low word at that address first, then the high word at address+4. A read completes on a cycle where `mem_rd_valid` and `mem_rd_ready` are both high, and `mem_rd_data` is taken in that cycle. While a read waits, `mem_rd_valid` and `mem_rd_addr` stay unchanged.
- R4: If index×8+7 is greater than the chosen table limit, the response carries fault code 1 (selector). No memory read is issued, and DPL, type and size are returned as 0.
- R5: The descriptor fields are laid out as follows. Low word: limit[15:0] = bits 15:0, base[15:0] = bits 31:16. High word: base[23:16] = bits 7:0, type = bits 11:8, DPL = bits 14:13, present = bit 15, limit[19:16] = bits 19:16, default size = bit 22, granularity = bit 23, base[31:24] = bits 31:24. Bits 12, 20 and 21 are ignored.
- R6: When the present bit is 0, the response carries fault code 2 (not present). This fault takes priority over the limit check.
- R7: With granularity 0 the effective limit is the 20-bit limit. With granularity 1 it is (limit<<12)|0xFFF.
- R8: A present descriptor whose offset is greater than the effective limit gives fault code 3 (limit). An offset equal to the limit is allowed.
- R9: With no fault, the linear address is base + offset, modulo 2^32. On any fault the linear address is 0, and fault code 0 means success.
- R10: A response is a one-cycle `rsp_valid` pulse that carries DPL, type and default size from the fetched descriptor. `req_ready` is high only while no translation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Unit idle, request accepted when valid |
| req_sel | input | 16 | Selector |
| req_off | input | 32 | Offset |
| gtab_base | input | 32 | Global table base |
| gtab_lim | input | 16 | Global table limit (last valid byte) |
| ltab_base | input | 32 | Local table base |
| ltab_lim | input | 16 | Local table limit (last valid byte) |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_addr | output | 32 | Descriptor word address |
| mem_rd_ready | input | 1 | Read completes this cycle |
| mem_rd_data | input | 32 | Read data, valid with ready |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_lin | output | 32 | Linear address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 selector, 2 not present, 3 limit |
| rsp_dpl | output | 2 | Descriptor privilege |
| rsp_rpl | output | 2 | Requested privilege |
| rsp_type | output | 4 | Descriptor type |
| rsp_dsize | output | 1 | Default operand size flag |

## Verification
A wrong table choice or a wrong index scaling appears at once on `mem_rd_addr`, in the first read of that translation. The memory model checks every read address against the address it computed itself. A descriptor word that is swapped or captured at the wrong time corrupts the base, limit or attribute fields, and this shows up in the response a few cycles later. A broken bound or granularity comparison changes the fault code, both for offsets exactly on the limit and for offsets one past it. A selector fault that still reaches memory is seen as an unexpected read before the response.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int DESC_LIM_W = 20;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_SEL  = 2'd1,
    FLT_NP   = 2'd2,
    FLT_LIM  = 2'd3
  } flt_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CHK  = 3'd1,
    ST_RD0  = 3'd2,
    ST_RD1  = 3'd3,
    ST_RESP = 3'd4
  } fsm_e;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int TLIM_W = 16
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] gtab_base,
  input  logic [TLIM_W-1:0] gtab_lim,
  input  logic [ADDR_W-1:0] ltab_base,
  input  logic [TLIM_W-1:0] ltab_lim,
  output logic [ADDR_W-1:0] desc_addr,
  output logic              sel_oob
);
  localparam int IDX_W = SEL_W - 3;

  logic [IDX_W-1:0]  idx;
  logic              use_local;
  logic [ADDR_W-1:0] tbl_base;
  logic [ADDR_W-1:0] tbl_lim_ext;
  logic [ADDR_W-1:0] entry_last;
  logic [1:0]        unused_rpl;

  assign idx        = sel[SEL_W-1:3];
  assign use_local  = sel[2];
  assign unused_rpl = sel[1:0];

  // R2: table choice
  always_comb begin
    if (use_local) begin
      tbl_base    = ltab_base;
      tbl_lim_ext = {{(ADDR_W-TLIM_W){1'b0}}, ltab_lim};
    end else begin
      tbl_base    = gtab_base;
      tbl_lim_ext = {{(ADDR_W-TLIM_W){1'b0}}, gtab_lim};
    end
  end

  // R3 / R4: entry address and bound on its last byte
  assign entry_last = {{(ADDR_W-SEL_W){1'b0}}, idx, 3'b111};
  assign desc_addr  = tbl_base + {{(ADDR_W-SEL_W){1'b0}}, idx, 3'b000};
  assign sel_oob    = entry_last > tbl_lim_ext;
endmodule

// File: rtl/seg_fetch_fsm.sv
module seg_fetch_fsm
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              accept,
  input  logic              sel_oob,
  input  logic [ADDR_W-1:0] desc_addr,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ready,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic [DATA_W-1:0] word_lo,
  output logic [DATA_W-1:0] word_hi,
  output logic              sel_flt,
  output logic              rsp_valid
);
  localparam logic [ADDR_W-1:0] HI_STEP = ADDR_W'(DATA_W / 8);

  fsm_e state_q, state_d;
  logic lo_en, hi_en, flt_en;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req_valid)    state_d = ST_CHK;
      ST_CHK:  state_d = sel_oob ? ST_RESP : ST_RD0;
      ST_RD0:  if (mem_rd_ready) state_d = ST_RD1;
      ST_RD1:  if (mem_rd_ready) state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign accept       = req_ready && req_valid;
  assign mem_rd_valid = (state_q == ST_RD0) || (state_q == ST_RD1);
  assign mem_rd_addr  = (state_q == ST_RD1) ? desc_addr + HI_STEP : desc_addr;
  assign rsp_valid    = (state_q == ST_RESP);
  assign lo_en        = (state_q == ST_RD0) && mem_rd_ready;
  assign hi_en        = (state_q == ST_RD1) && mem_rd_ready;
  assign flt_en       = (state_q == ST_CHK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_lo <= '0;
      word_hi <= '0;
      sel_flt <= 1'b0;
    end else begin
      if (lo_en)  word_lo <= mem_rd_data;
      if (hi_en)  word_hi <= mem_rd_data;
      if (flt_en) sel_flt <= sel_oob;
    end
  end

  AST_NO_READ_ON_SEL_FLT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHK && sel_oob) |=> !mem_rd_valid); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R3
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R10
endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [31:0]       word_lo,
  input  logic [31:0]       word_hi,
  input  logic [ADDR_W-1:0] offset,
  input  logic              sel_flt,
  output logic [ADDR_W-1:0] lin,
  output logic [1:0]        fault,
  output logic [1:0]        dpl,
  output logic [3:0]        dtype,
  output logic              dsize
);
  logic [31:0]           seg_base;
  logic [DESC_LIM_W-1:0] seg_lim;
  logic                  gran, present;
  logic [ADDR_W-1:0]     eff_lim;
  logic [2:0]            unused_hi_bits;

  // R5: reassemble scattered fields
  assign seg_base       = {word_hi[31:24], word_hi[7:0], word_lo[31:16]};
  assign seg_lim        = {word_hi[19:16], word_lo[15:0]};
  assign gran           = word_hi[23];
  assign present        = word_hi[15];
  assign unused_hi_bits = {word_hi[21:20], word_hi[12]};

  // R7: granularity scaling
  always_comb begin
    if (gran) eff_lim = ADDR_W'({seg_lim, 12'hFFF});
    else      eff_lim = ADDR_W'(seg_lim);
  end

  // R4 / R6 / R8 / R9: fault priority and result
  always_comb begin
    lin   = '0;
    dpl   = word_hi[14:13];
    dtype = word_hi[11:8];
    dsize = word_hi[22];
    if (sel_flt) begin
      fault = FLT_SEL;
      dpl   = '0;
      dtype = '0;
      dsize = 1'b0;
    end else if (!present) begin
      fault = FLT_NP;
    end else if (offset > eff_lim) begin
      fault = FLT_LIM;
    end else begin
      fault = FLT_NONE;
      lin   = ADDR_W'(seg_base) + offset;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int TLIM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [ADDR_W-1:0] req_off,
  input  logic [ADDR_W-1:0] gtab_base,
  input  logic [TLIM_W-1:0] gtab_lim,
  input  logic [ADDR_W-1:0] ltab_base,
  input  logic [TLIM_W-1:0] ltab_lim,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ready,
  input  logic [31:0]       mem_rd_data,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_lin,
  output logic [1:0]        rsp_fault,
  output logic [1:0]        rsp_dpl,
  output logic [1:0]        rsp_rpl,
  output logic [3:0]        rsp_type,
  output logic              rsp_dsize
);
  logic              rst_meta, rst_sync;
  logic              accept;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] off_q;
  logic [ADDR_W-1:0] desc_addr;
  logic              sel_oob, sel_flt;
  logic [31:0]       word_lo, word_hi;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      sel_q <= '0;
      off_q <= '0;
    end else if (accept) begin
      sel_q <= req_sel;
      off_q <= req_off;
    end
  end

  assign rsp_rpl = sel_q[1:0]; // R1

  seg_sel_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .TLIM_W(TLIM_W)) u_dec (
    .sel(sel_q), .gtab_base(gtab_base), .gtab_lim(gtab_lim),
    .ltab_base(ltab_base), .ltab_lim(ltab_lim),
    .desc_addr(desc_addr), .sel_oob(sel_oob)
  );

  seg_fetch_fsm #(.ADDR_W(ADDR_W), .DATA_W(32)) u_fsm (
    .clk(clk), .rst_n(rst_sync), .req_valid(req_valid), .req_ready(req_ready),
    .accept(accept), .sel_oob(sel_oob), .desc_addr(desc_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
    .word_lo(word_lo), .word_hi(word_hi), .sel_flt(sel_flt),
    .rsp_valid(rsp_valid)
  );

  seg_desc_check #(.ADDR_W(ADDR_W)) u_chk (
    .word_lo(word_lo), .word_hi(word_hi), .offset(off_q), .sel_flt(sel_flt),
    .lin(rsp_lin), .fault(rsp_fault), .dpl(rsp_dpl), .dtype(rsp_type),
    .dsize(rsp_dsize)
  );

  AST_FAULT_LIN_ZERO: assert property (@(posedge clk) disable iff (!rst_sync)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_lin == '0)); // R9
  AST_RPL_STABLE: assert property (@(posedge clk) disable iff (!rst_sync)
    (!req_ready && !accept) |=> $stable(rsp_rpl)); // R1
endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  typedef struct {
    logic [31:0] lin;
    logic [1:0]  fault;
    logic [1:0]  dpl;
    logic [1:0]  rpl;
    logic [3:0]  typ;
    logic        dsz;
    int          nreads;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_sel;
  logic [31:0] req_off;
  logic [31:0] gtab_base, ltab_base;
  logic [15:0] gtab_lim, ltab_lim;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ready;
  logic [31:0] mem_rd_data;
  logic        rsp_valid;
  logic [31:0] rsp_lin;
  logic [1:0]  rsp_fault, rsp_dpl, rsp_rpl;
  logic [3:0]  rsp_type;
  logic        rsp_dsize;

  int checks = 0;
  int fails  = 0;
  exp_t sb_q[$];
  exp_t e;
  logic [31:0] cur_addr, cur_lo, cur_hi;
  int rd_count = 0;
  int stall_cfg = 0;
  int stall_cnt = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_off(req_off), .gtab_base(gtab_base), .gtab_lim(gtab_lim),
    .ltab_base(ltab_base), .ltab_lim(ltab_lim), .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_lin(rsp_lin), .rsp_fault(rsp_fault), .rsp_dpl(rsp_dpl),
    .rsp_rpl(rsp_rpl), .rsp_type(rsp_type), .rsp_dsize(rsp_dsize)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: R3 address order and hold
  always @(negedge clk) begin
    mem_rd_ready = 1'b0;
    if (rst_n && mem_rd_valid) begin
      if (stall_cnt == 0) begin
        mem_rd_ready = 1'b1;
        chk(mem_rd_addr == cur_addr + 32'(4 * rd_count), "R3 read address",
            mem_rd_addr, cur_addr + 32'(4 * rd_count));
        mem_rd_data = (rd_count == 0) ? cur_lo : cur_hi;
        rd_count++;
        stall_cnt = stall_cfg;
      end else begin
        stall_cnt--;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10 unexpected response", 32'(rsp_fault), 32'hFFFF_FFFF);
      end else begin
        e = sb_q.pop_front();
        chk(rsp_lin == e.lin, "R9 linear address", rsp_lin, e.lin);
        chk(rsp_fault == e.fault, "R4/R6/R8 fault code", 32'(rsp_fault), 32'(e.fault));
        chk(rsp_rpl == e.rpl, "R1 rpl", 32'(rsp_rpl), 32'(e.rpl));
        chk(rsp_dpl == e.dpl, "R10 dpl", 32'(rsp_dpl), 32'(e.dpl));
        chk(rsp_type == e.typ, "R10 type", 32'(rsp_type), 32'(e.typ));
        chk(rsp_dsize == e.dsz, "R10 dsize", 32'(rsp_dsize), 32'(e.dsz));
        chk(rd_count == e.nreads, "R3/R4 read count", 32'(rd_count), 32'(e.nreads));
      end
    end
  end

  // driver: build the descriptor per R5, predict per R1..R10, issue request
  task automatic xlate(input logic [15:0] sel, input logic [31:0] off,
                       input logic [31:0] dbase, input logic [19:0] dlim,
                       input bit g, input bit d, input bit p,
                       input logic [1:0] dpl, input logic [3:0] typ);
    exp_t x;
    logic [12:0] idx;
    logic [31:0] tb, tl, eff;
    idx = sel[15:3];
    tb  = sel[2] ? ltab_base : gtab_base;
    tl  = sel[2] ? 32'(ltab_lim) : 32'(gtab_lim);
    x.rpl = sel[1:0];
    x.lin = '0;
    if ({19'b0, idx, 3'b111} > tl) begin
      x.fault = 2'd1; x.nreads = 0; x.dpl = 0; x.typ = 0; x.dsz = 0;
    end else begin
      x.nreads = 2; x.dpl = dpl; x.typ = typ; x.dsz = d;
      eff = g ? {dlim, 12'hFFF} : {12'h0, dlim};
      if (!p) x.fault = 2'd2;
      else if (off > eff) x.fault = 2'd3;
      else begin x.fault = 2'd0; x.lin = dbase + off; end
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_addr = tb + {19'b0, idx, 3'b000};
    cur_lo   = {dbase[15:0], dlim[15:0]};
    cur_hi   = {dbase[31:24], g, d, 2'b11, dlim[19:16], p, dpl, 1'b1, typ, dbase[23:16]};
    rd_count = 0;
    stall_cnt = stall_cfg;
    sb_q.push_back(x);
    req_sel = sel; req_off = off; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_sel = '1; req_off = '1;
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        chk(1'b0, "watchdog", 32'(cycles), 32'd20000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_sel = '0; req_off = '0;
    mem_rd_ready = 1'b0; mem_rd_data = '0;
    gtab_base = 32'h0000_1000; gtab_lim = 16'h00FF;
    ltab_base = 32'h8000_0000; ltab_lim = 16'h001F;
    cur_addr = '0; cur_lo = '0; cur_hi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R10 reset ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R10 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk(mem_rd_valid == 1'b0, "R3 reset read idle", 32'(mem_rd_valid), 32'd0);

    // R1 R2 R5 R9: global table, byte granularity
    xlate({13'd5, 1'b0, 2'd3}, 32'h100, 32'h1234_5678, 20'h0FFFF, 0, 1, 1, 2'd2, 4'hA);
    // R2 R7: local table, last entry exactly at limit, 4K granularity, offset at limit
    stall_cfg = 2;
    xlate({13'd3, 1'b1, 2'd1}, 32'h2FFF, 32'hFFFF_F000, 20'h00002, 1, 0, 1, 2'd1, 4'h3);
    // R8: one past scaled limit
    xlate({13'd3, 1'b1, 2'd0}, 32'h3000, 32'h0000_4000, 20'h00002, 1, 1, 1, 2'd3, 4'h2);
    // R4: local entry past table limit, no reads
    stall_cfg = 0;
    xlate({13'd4, 1'b1, 2'd2}, 32'h0, 32'h1111_1111, 20'hFFFFF, 1, 1, 1, 2'd0, 4'hF);
    // R2: same index in global table is in bounds
    xlate({13'd4, 1'b0, 2'd2}, 32'h10, 32'h0A0B_0C0D, 20'h00100, 0, 0, 1, 2'd0, 4'h9);
    // R6: not present beats limit fault
    stall_cfg = 1;
    xlate({13'd7, 1'b0, 2'd0}, 32'hFFFF_0000, 32'h0, 20'h00001, 0, 1, 0, 2'd1, 4'h8);
    // R7 R8: byte granularity at and past full limit
    xlate({13'd31, 1'b0, 2'd1}, 32'h000F_FFFF, 32'h00C0_0000, 20'hFFFFF, 0, 1, 1, 2'd0, 4'hB);
    xlate({13'd31, 1'b0, 2'd1}, 32'h0010_0000, 32'h00C0_0000, 20'hFFFFF, 0, 1, 1, 2'd0, 4'hB);
    // R9: wrap-around add with full 4K limit
    xlate({13'd1, 1'b0, 2'd3}, 32'hFFFF_FFF0, 32'h0000_0020, 20'hFFFFF, 1, 0, 1, 2'd3, 4'h1);
    // R4: global entry past limit at the top index
    gtab_lim = 16'hFFF7;
    xlate({13'h1FFF, 1'b0, 2'd0}, 32'h0, 32'h0, 20'h0, 0, 0, 1, 2'd0, 4'h0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule